// File: doc/BRIEF.md
# Clock Pulse Count Write Guard

This block protects a serial non-volatile memory from instructions that were corrupted by noise on the serial clock. Over one chip-select frame it counts the rising serial clock edges, starting at the start bit and ending when chip select drops. When chip select falls, it compares that count with the exact length of the instruction that was decoded, for the organization currently selected. A programming cycle is allowed only when the two match. A glitch that adds a clock pulse shifts every later bit by one position and can change both the address and the data. Requiring an exact count rejects such a frame before anything is written.

The block sits between the serial front end and the programming sequencer. The front end supplies four things: a one-cycle strobe for each sampled rising serial clock edge, the data bit sampled on that edge, the chip-select level, and the decoded op-code fields. These fields must be held valid while chip select falls. The guard answers each frame that carries a modifying instruction with exactly one single-cycle pulse: commit starts the self-timed cycle and abort discards the instruction. The memory array and the shifting of address and data are outside this block.

Top module: `clk_count_guard`

## Requirements
- R1: During and directly after a synchronous active-low reset, the commit and abort outputs are low and no frame is open.
- R2: A frame opens on the first sampled rising serial edge where chip select is high and the data bit is 1. Earlier edges that carry 0 are not counted. That start edge counts as 1, and every later sampled edge with chip select high adds 1.
- R3: The 2-bit op-code decodes as follows: 01 is write, 11 is erase, 10 is read. Op-code 00 selects an extended instruction through the 2-bit extension field, which holds the two most significant address bits: 10 is erase-all, 01 is write-all, 11 is program-enable and 00 is program-disable.
- R4: Let A be the address width, equal to ADDR_W when the organization input is 1 (16-bit words) and ADDR_W+1 when it is 0 (bytes). Let D be the data width, 16 or 8 respectively. The expected count is 3+A+D for write and write-all, and 3+A for erase and erase-all.
- R5: For a modifying instruction whose count equals the expected count, commit is high for exactly one clock cycle. That cycle is the one after the clock edge at which chip select is first sampled low.
- R6: For a modifying instruction with any other count, either too few or too many edges, abort is high for exactly one cycle with the same timing, and commit stays low.
- R7: Read, program-enable and program-disable produce neither pulse, whatever the count.
- R8: A chip-select fall in a frame that never saw a start bit produces neither pulse.
- R9: The counter saturates at its all-ones value. A frame that carries the expected count plus a multiple of the counter range therefore aborts and never commits.
- R10: Commit and abort are never high together, and each frame yields at most one of them.
- R11: A serial edge strobe in the cycle where chip select is already sampled low is not counted. The next frame counts from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_rise | input | 1 | One-cycle strobe for each sampled rising serial clock edge |
| cs | input | 1 | Chip-select level, sampled synchronously |
| sdi | input | 1 | Serial data bit sampled with the edge strobe |
| opcode | input | 2 | Decoded op-code, held valid when chip select falls |
| ext_code | input | 2 | Extension field (two top address bits), held valid when chip select falls |
| org_wide | input | 1 | Organization: 1 selects 16-bit words, 0 selects bytes |
| commit | output | 1 | One-cycle pulse that starts the programming cycle |
| abort | output | 1 | One-cycle pulse that discards the instruction |

## Verification
A wrong counter value or a wrong expected count cannot be seen inside a frame. It appears only in the cycle after chip select is sampled low, where a commit turns into an abort or the reverse. For that reason the sweep closes frames one, two and zero edges either side of each instruction's exact length, in both organizations. A counter that wraps instead of saturating shows up as a commit on a frame that is far too long. A frame flag that is not cleared shows up in the following frame as a count that is off by the stale value.

// File: rtl/ccg_pkg.sv
// Package shared by the clock pulse count guard.
// It holds the instruction classes and the helper that derives the
// expected frame length. It assumes a 2-bit op-code plus a 2-bit extension.
package ccg_pkg;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERASE_ALL,
        CMD_WRITE_ALL,
        CMD_PROG_EN,
        CMD_PROG_DIS
    } cmd_e;

    localparam int unsigned HDR_BITS = 3;  // start bit plus two op-code bits

    // Expected edge count for a command class. Returns 0 for classes that are never checked.
    function automatic int unsigned frame_len(cmd_e c, int unsigned a_bits, int unsigned d_bits);
        case (c)
            CMD_WRITE, CMD_WRITE_ALL: return HDR_BITS + a_bits + d_bits;
            CMD_ERASE, CMD_ERASE_ALL: return HDR_BITS + a_bits;
            default:                  return 0;
        endcase
    endfunction

endpackage

// File: rtl/ccg_decode.sv
// Instruction class decoder.
// It maps op-code and extension to a command class and flags the classes
// that modify memory. Purely combinational; the inputs are assumed stable.
module ccg_decode
    import ccg_pkg::*;
(
    input  logic [1:0] opcode,
    input  logic [1:0] ext_code,
    output cmd_e       cmd,
    output logic       modifies
);

    // Decode the command class from the two op-code fields.
    always_comb begin
        case (opcode)
            2'b01:   cmd = CMD_WRITE;
            2'b11:   cmd = CMD_ERASE;
            2'b10:   cmd = CMD_READ;
            default: begin
                case (ext_code)
                    2'b10:   cmd = CMD_ERASE_ALL;
                    2'b01:   cmd = CMD_WRITE_ALL;
                    2'b11:   cmd = CMD_PROG_EN;
                    default: cmd = CMD_PROG_DIS;
                endcase
            end
        endcase
    end

    // Flag the classes that are subject to the count check.
    always_comb begin
        modifies = (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
                   (cmd == CMD_ERASE_ALL) || (cmd == CMD_WRITE_ALL);
    end

endmodule

// File: rtl/ccg_expect.sv
// Expected count generator.
// It gives the exact number of serial edges a command needs for the selected
// organization. The byte mode is assumed to use one more address bit than the word mode.
module ccg_expect
    import ccg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned CNT_W    = 5
) (
    input  cmd_e             cmd,
    input  logic             org_wide,
    output logic [CNT_W-1:0] exp_cnt
);

    localparam int unsigned A_WIDE   = ADDR_W;
    localparam int unsigned A_NARROW = ADDR_W + 1;

    // Select the length for the current organization.
    always_comb begin
        if (org_wide)
            exp_cnt = CNT_W'(frame_len(cmd, A_WIDE, WIDE_W));
        else
            exp_cnt = CNT_W'(frame_len(cmd, A_NARROW, NARROW_W));
    end

endmodule

// File: rtl/ccg_counter.sv
// Frame edge counter.
// It opens a frame on the first 1 sampled with chip select high, counts the
// edges that follow (saturating), and flags the chip-select fall of an open frame.
module ccg_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             cs,
    input  logic             sdi,
    output logic [CNT_W-1:0] cnt,
    output logic             in_frame,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic cs_q;

    // Remember the previous chip-select sample for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs;
    end

    // Open the frame at the start bit and count the edges, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            in_frame <= 1'b0;
            cnt      <= '0;
        end else if (sclk_rise) begin
            if (!in_frame) begin
                if (sdi) begin
                    in_frame <= 1'b1;
                    cnt      <= CNT_W'(1);
                end
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // An open frame ends in the cycle where chip select is first seen low.
    always_comb frame_end = cs_q && !cs && in_frame;

endmodule

// File: rtl/clk_count_guard.sv
// Clock pulse count write guard (top).
// At each chip-select fall it compares the frame's edge count with the expected
// length of the decoded instruction, and issues a registered one-cycle commit or
// abort for modifying instructions. The op-code inputs must be valid at the fall.
module clk_count_guard #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned WIDE_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       cs,
    input  logic       sdi,
    input  logic [1:0] opcode,
    input  logic [1:0] ext_code,
    input  logic       org_wide,
    output logic       commit,
    output logic       abort
);
    import ccg_pkg::*;

    localparam int unsigned MAX_LEN = HDR_BITS + ADDR_W + 1 +
                                      ((WIDE_W > NARROW_W) ? WIDE_W : NARROW_W);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2);

    cmd_e             cmd;
    logic             modifies;
    logic [CNT_W-1:0] exp_cnt;
    logic [CNT_W-1:0] cnt;
    logic             in_frame;
    logic             frame_end;

    ccg_decode u_decode (
        .opcode   (opcode),
        .ext_code (ext_code),
        .cmd      (cmd),
        .modifies (modifies)
    );

    ccg_expect #(
        .ADDR_W   (ADDR_W),
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .CNT_W    (CNT_W)
    ) u_expect (
        .cmd      (cmd),
        .org_wide (org_wide),
        .exp_cnt  (exp_cnt)
    );

    ccg_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .cs        (cs),
        .sdi       (sdi),
        .cnt       (cnt),
        .in_frame  (in_frame),
        .frame_end (frame_end)
    );

    // Register the verdict of a closing frame as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0;
            abort  <= 1'b0;
        end else begin
            commit <= frame_end && modifies && (cnt == exp_cnt);
            abort  <= frame_end && modifies && (cnt != exp_cnt);
        end
    end

endmodule

// File: rtl/ccg_checker.sv
// Property checker for the clock pulse count guard, bound to the top module.
// It observes the ports and the counter state; it drives nothing.
module ccg_checker #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             commit,
    input logic             abort,
    input logic             modifies,
    input logic             in_frame,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && abort)); // R10

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R5

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort); // R6

    AST_COMMIT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!$past(cs) && $past(cs, 2))); // R5

    AST_ABORT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!$past(cs) && $past(cs, 2))); // R6

    AST_ONLY_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || abort) |-> $past(modifies)); // R7

    AST_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || abort) |-> $past(in_frame)); // R8

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && cs) |=> (cnt == CNT_MAX)); // R9

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (cnt == '0 && !in_frame)); // R11

endmodule

bind clk_count_guard ccg_checker #(.CNT_W(CNT_W)) u_ccg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .commit   (commit),
    .abort    (abort),
    .modifies (modifies),
    .in_frame (in_frame),
    .cnt      (cnt)
);

// File: tb/clk_count_guard_tb.sv
// Sweep bench for the clock pulse count guard, default configuration (ADDR_W = 6).
module clk_count_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       cs = 1'b0;
    logic       sdi = 1'b0;
    logic [1:0] opcode = 2'b00;
    logic [1:0] ext_code = 2'b00;
    logic       org_wide = 1'b1;
    logic       commit;
    logic       abort;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam int ADDR_W = 6;

    always #2.5 clk = ~clk;

    clk_count_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .cs        (cs),
        .sdi       (sdi),
        .opcode    (opcode),
        .ext_code  (ext_code),
        .org_wide  (org_wide),
        .commit    (commit),
        .abort     (abort)
    );

    // Expected length from R3/R4; 0 means a non-modifying instruction.
    function automatic int exp_len(logic [1:0] op, logic [1:0] ex, logic org);
        int a;
        int d;
        a = org ? ADDR_W : ADDR_W + 1;
        d = org ? 16 : 8;
        if (op == 2'b01) return 3 + a + d;
        if (op == 2'b11) return 3 + a;
        if (op == 2'b10) return 0;
        if (ex == 2'b10) return 3 + a;
        if (ex == 2'b01) return 3 + a + d;
        return 0;
    endfunction

    task automatic check(string req, logic [1:0] got, logic [1:0] want);
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: {commit,abort} actual %b expected %b", req, got, want);
        end
    endtask

    task automatic pulse(logic bitv);
        @(negedge clk);
        sdi = bitv;
        sclk_rise = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
    endtask

    // One frame: nzero leading zeros, then nedges edges starting with the start bit.
    task automatic frame(logic [1:0] op, logic [1:0] ex, logic org, int nzero, int nedges,
                         bit edge_at_fall, string req);
        int e;
        logic [1:0] want;
        e = exp_len(op, ex, org);
        opcode = op; ext_code = ex; org_wide = org;
        @(negedge clk);
        cs = 1'b1;
        for (int i = 0; i < nzero; i++) pulse(1'b0);
        for (int i = 0; i < nedges; i++) pulse((i == 0) ? 1'b1 : logic'(i[1]));
        @(negedge clk);
        cs = 1'b0;
        sclk_rise = edge_at_fall;
        sdi = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
        if (e == 0 || nedges == 0) want = 2'b00;
        else if (nedges == e)      want = 2'b10;
        else                       want = 2'b01;
        check(req, {commit, abort}, want);
        @(negedge clk);
        check(req, {commit, abort}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {commit, abort}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {commit, abort}, 2'b00);

        // R3 R4 R5 R6 R7: every op/extension/organization at exact and near lengths
        for (int op = 0; op < 4; op++)
            for (int ex = 0; ex < 4; ex++)
                for (int org = 0; org < 2; org++)
                    for (int dl = -2; dl <= 2; dl++) begin
                        int base;
                        base = exp_len(2'(op), 2'(ex), 1'(org));
                        if (base == 0) base = 12;
                        frame(2'(op), 2'(ex), 1'(org), (op + dl + 2) % 3, base + dl, 1'b0,
                              "R4/R5/R6/R7");
                    end

        // R2: long run of leading zeros before an exact write
        frame(2'b01, 2'b00, 1'b1, 9, exp_len(2'b01, 2'b00, 1'b1), 1'b0, "R2");
        // R8: chip-select fall with no start bit
        frame(2'b01, 2'b00, 1'b0, 6, 0, 1'b0, "R8");
        frame(2'b11, 2'b00, 1'b1, 0, 0, 1'b0, "R8");
        // R9: expected plus a full counter range must abort (5-bit counter, range 32)
        frame(2'b01, 2'b00, 1'b1, 0, exp_len(2'b01, 2'b00, 1'b1) + 32, 1'b0, "R9");
        frame(2'b11, 2'b00, 1'b0, 0, exp_len(2'b11, 2'b00, 1'b0) + 32, 1'b0, "R9");
        // R11: an edge strobe coinciding with the fall is not counted
        frame(2'b01, 2'b00, 1'b0, 1, exp_len(2'b01, 2'b00, 1'b0), 1'b1, "R11");
        frame(2'b00, 2'b10, 1'b1, 0, exp_len(2'b00, 2'b10, 1'b1), 1'b1, "R11");
        // R10/R11: an aborted frame leaves no residue in the next one
        frame(2'b00, 2'b01, 1'b0, 0, exp_len(2'b00, 2'b01, 1'b0) + 1, 1'b0, "R10");
        frame(2'b00, 2'b01, 1'b0, 0, exp_len(2'b00, 2'b01, 1'b0), 1'b0, "R11");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule